// File: doc/BRIEF.md
# Host-to-ISA I/O Window Bridge

This block sits between a processor's memory-mapped bus and a legacy ISA-style port bus. The processor reaches I/O ports through an 8 MB region. The bridge checks whether each access falls inside that region, turns the offset into a 16-bit port number, and reorders the data bytes so that the processor's big-endian lanes meet the port bus's little-endian lanes. It then runs one port cycle and waits for that cycle to be acknowledged.

Two address mappings are available. A flat mapping uses the bottom 16 offset bits as the port. A page-spread mapping takes offset bits 22..12 as port bits 15..5 and keeps offset bits 4..0 as port bits 4..0, so each 4 KB page shows 32 ports. A byte-wide mode register, held inside the bridge, chooses between them.

A small bank of system-control ports is served inside the bridge and never reaches the port bus. It holds fixed identification values, a cache-control register and the mode register. Any port in that range with no register behind it reads as all ones.

Top module: `isa_io_bridge`

## Requirements
- R1: An access is inside the window when 0x8000_0000 <= h_addr <= 0x807F_FFFF. An access outside it finishes without a port cycle. Its read data is 0xFFFF_FFFF.
- R2: After reset the mode register is 0 (flat mapping). In flat mapping the port is the window offset's bits 15..0.
- R3: When the mode register is nonzero, the port is (offset & 0x1F) | ((offset & 0x7FF000) >> 7).
- R4: The mode register is read and written as a byte at port 0x0850. A nonzero write selects page-spread mapping from the next access onward, and a zero write restores flat mapping.
- R5: h_size and io_size encode 0 = byte, 1 = halfword, 2 = word. On a forwarded write, io_wdata is {24'h0, d[7:0]} for a byte, {16'h0, d[7:0], d[15:8]} for a halfword, and the four bytes of d in reverse order for a word.
- R6: On a forwarded read, h_rdata is io_rdata after the same size-dependent lane reordering and zero fill as in R5.
- R7: Port 0x0092 and ports 0x0800 to 0x0851 are served internally with no port cycle. These ports are byte-wide: h_wdata[7:0] is the write data, and the value read appears in h_rdata[7:0] with the upper bits zero. No lane reordering applies, whatever the size.
- R8: Ports 0x0092 and 0x0818 read 0x00, port 0x0800 reads 0xEF, and port 0x080C reads 0x3C. Any other internal port with no register behind it reads 0xFF.
- R9: Port 0x081C is a read/write register that resets to 0. It keeps bits 7, 6, 1 and 0 of a written byte; the other bits read as 0.
- R10: A write to port 0x0814 is accepted and changes no register. A read of 0x0814 returns 0xFF.
- R11: Each forwarded access raises io_req once. io_req and its port, size, direction and data stay steady until io_ack. h_ready is a single-cycle completion pulse that carries h_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Processor access request, held until h_ready |
| h_we | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | Access size (0 byte, 1 half, 2 word) |
| h_addr | input | 32 | Processor physical address |
| h_wdata | input | 32 | Processor write data |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read data, valid with h_ready |
| io_req | output | 1 | Port cycle request, held until io_ack |
| io_we | output | 1 | Port cycle direction (1 = write) |
| io_size | output | 2 | Port cycle size |
| io_port | output | 16 | Port number |
| io_wdata | output | 32 | Lane-reordered write data |
| io_rdata | input | 32 | Port read data, sampled with io_ack |
| io_ack | input | 1 | Port cycle acknowledge |

## Verification
The assertions assume that the processor holds h_valid and its fields steady until h_ready, and lowers h_valid in the cycle h_ready is seen. They also assume that io_ack is raised only while io_req is high, and for one cycle. The bench's host task drives inputs only on falling edges and drops h_valid as soon as it sees the completion pulse. Its port-bus responder waits a latency taken from the port's low bits, then acknowledges once and clears the acknowledge on the next falling edge. Size code 3 is never driven.

// File: rtl/iobr_pkg.sv
package iobr_pkg;
  localparam int DW       = 32;
  localparam int PW       = 16;
  localparam int WIN_BITS = 23;
  localparam logic [31:0] WIN_BASE_DEF = 32'h8000_0000;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} iobr_size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_DONE = 2'd2} iobr_state_e;

  localparam logic [PW-1:0] P_GATE    = 16'h0092;
  localparam logic [PW-1:0] P_BANK_LO = 16'h0800;
  localparam logic [PW-1:0] P_BANK_HI = 16'h0851;
  localparam logic [PW-1:0] P_CPUID   = 16'h0800;
  localparam logic [PW-1:0] P_EQUIP   = 16'h080C;
  localparam logic [PW-1:0] P_FLUSH   = 16'h0814;
  localparam logic [PW-1:0] P_LOCK    = 16'h0818;
  localparam logic [PW-1:0] P_CACHE   = 16'h081C;
  localparam logic [PW-1:0] P_MODE    = 16'h0850;
  localparam logic [7:0]    CACHE_KEEP = 8'hC3;

  // Window offset to port number for either mapping.
  function automatic logic [PW-1:0] remap_port(logic [WIN_BITS-1:0] off, logic spread);
    if (spread) return {off[WIN_BITS-1:12], off[4:0]};
    return off[PW-1:0];
  endfunction

  // True for ports answered by the internal register bank.
  function automatic logic bank_hit(logic [PW-1:0] p);
    return (p == P_GATE) || ((p >= P_BANK_LO) && (p <= P_BANK_HI));
  endfunction

  // Size-dependent lane reordering with zero fill.
  function automatic logic [DW-1:0] lane_swap(logic [1:0] sz, logic [DW-1:0] d);
    case (sz)
      SZ_BYTE: return {24'h0, d[7:0]};
      SZ_HALF: return {16'h0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction
endpackage

// File: rtl/iobr_decode.sv
module iobr_decode
  import iobr_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = WIN_BASE_DEF
) (
  input  logic [31:0]   addr,
  input  logic          spread,
  output logic          in_win,
  output logic [PW-1:0] port
);
  localparam int TAG_W = 32 - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[31:WIN_BITS];

  always_comb begin
    in_win = (addr[31:WIN_BITS] == WIN_TAG);
    port   = remap_port(addr[WIN_BITS-1:0], spread);
  end
endmodule

// File: rtl/iobr_lane_swap.sv
module iobr_lane_swap
  import iobr_pkg::*;
(
  input  logic [1:0]    size,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_comb dout = lane_swap(size, din);
endmodule

// File: rtl/iobr_sysregs.sv
module iobr_sysregs
  import iobr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          we,
  input  logic [PW-1:0] port,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          spread
);
  logic [7:0] cache_q;
  logic [7:0] mode_q;

  logic wr_mode_evt, wr_flush_evt;
  assign wr_mode_evt  = acc && we && (port == P_MODE);
  assign wr_flush_evt = acc && we && (port == P_FLUSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_q <= 8'h00;
      mode_q  <= 8'h00;
    end else if (acc && we) begin
      case (port)
        P_CACHE: cache_q <= wdata & CACHE_KEEP;
        P_MODE:  mode_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (port)
      P_GATE, P_LOCK: rdata = 8'h00;
      P_CPUID:        rdata = 8'hEF;
      P_EQUIP:        rdata = 8'h3C;
      P_CACHE:        rdata = cache_q;
      P_MODE:         rdata = mode_q;
      default:        rdata = 8'hFF;
    endcase
  end

  assign spread = |mode_q;

  // R4: mapping choice follows the byte last written to the mode port
  a_r4_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode_evt |=> (spread == ($past(wdata) != 8'h00)));

  // R10: a flush-port write leaves every register unchanged
  a_r10_flush_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flush_evt |=> ($stable(cache_q) && $stable(mode_q)));

  // R9: cache register never holds bits outside the kept set
  a_r9_cache_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_q & ~CACHE_KEEP) == 8'h00);
endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge
  import iobr_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = WIN_BASE_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  input  logic          h_we,
  input  logic [1:0]    h_size,
  input  logic [31:0]   h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic          h_ready,
  output logic [DW-1:0] h_rdata,
  output logic          io_req,
  output logic          io_we,
  output logic [1:0]    io_size,
  output logic [PW-1:0] io_port,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  input  logic          io_ack
);
  localparam logic [DW-1:0] MISS_DATA = '1;

  iobr_state_e state_q;
  logic          spread, in_win;
  logic [PW-1:0] port;
  logic [7:0]    bank_rdata;
  logic [DW-1:0] wr_swapped, rd_swapped;

  // Named events for assertions
  logic accept, acc_bank, acc_miss, acc_fwd;
  assign accept   = (state_q == ST_IDLE) && h_valid;
  assign acc_bank = accept && in_win && bank_hit(port);
  assign acc_miss = accept && !in_win;
  assign acc_fwd  = accept && in_win && !bank_hit(port);

  iobr_decode #(.WIN_BASE(WIN_BASE)) i_decode (
    .addr(h_addr), .spread(spread), .in_win(in_win), .port(port)
  );

  iobr_sysregs i_sysregs (
    .clk(clk), .rst_n(rst_n), .acc(acc_bank), .we(h_we), .port(port),
    .wdata(h_wdata[7:0]), .rdata(bank_rdata), .spread(spread)
  );

  iobr_lane_swap i_wr_swap (.size(h_size),  .din(h_wdata),  .dout(wr_swapped));
  iobr_lane_swap i_rd_swap (.size(io_size), .din(io_rdata), .dout(rd_swapped));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      io_req   <= 1'b0;
      io_we    <= 1'b0;
      io_size  <= 2'd0;
      io_port  <= '0;
      io_wdata <= '0;
      h_rdata  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (acc_fwd) begin
            io_req   <= 1'b1;
            io_we    <= h_we;
            io_size  <= h_size;
            io_port  <= port;
            io_wdata <= h_we ? wr_swapped : '0;
            state_q  <= ST_WAIT;
          end else if (accept) begin
            if (h_we)          h_rdata <= '0;
            else if (acc_bank) h_rdata <= {24'h0, bank_rdata};
            else               h_rdata <= MISS_DATA;
            state_q <= ST_DONE;
          end
        end
        ST_WAIT: begin
          if (io_ack) begin
            io_req  <= 1'b0;
            h_rdata <= io_we ? '0 : rd_swapped;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign h_ready = (state_q == ST_DONE);

  // R11: request and its fields hold until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_ack) |=> (io_req && $stable(io_port) && $stable(io_wdata)
                             && $stable(io_we) && $stable(io_size)));

  // R11: completion is a single-cycle pulse
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |=> !h_ready);

  // R7: internal-bank accesses never start a port cycle
  a_r7_bank_local: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bank |=> (h_ready && !io_req));

  // R1: out-of-window accesses finish at once without a port cycle
  a_r1_miss_local: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> (h_ready && !io_req));

  // R5: byte writes carry zero in the upper lanes
  a_r5_byte_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_we && io_size == 2'd0) |-> (io_wdata[31:8] == 24'h0));
endmodule

// File: tb/test_isa_io_bridge.sv
module test_isa_io_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        h_valid = 0, h_we = 0;
  logic [1:0]  h_size = 0;
  logic [31:0] h_addr = 0, h_wdata = 0;
  logic        h_ready;
  logic [31:0] h_rdata;
  logic        io_req, io_we;
  logic [1:0]  io_size;
  logic [15:0] io_port;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata = 0;
  logic        io_ack = 0;

  isa_io_bridge i_isa_io_bridge (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_we(h_we), .h_size(h_size),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
    .io_req(io_req), .io_we(io_we), .io_size(io_size), .io_port(io_port),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack)
  );

  int checks = 0, failures = 0;
  int n_req = 0, delta = 0, wait_cnt = 0;
  logic [15:0] rec_port;
  logic [1:0]  rec_size;
  logic [31:0] rec_wdata;
  logic        rec_we;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] resp_data(logic [15:0] p);
    return {~p, p ^ 16'h5A3C};
  endfunction

  function automatic logic [15:0] want_port(logic [31:0] off, bit pages);
    logic [31:0] r;
    if (pages) r = (off & 32'h1F) | ((off & 32'h7FF000) >> 7);
    else       r = off & 32'hFFFF;
    return r[15:0];
  endfunction

  function automatic logic [31:0] want_swap(logic [1:0] sz, logic [31:0] d);
    if (sz == 2'd0) return d & 32'hFF;
    if (sz == 2'd1) return ((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF);
    return ((d & 32'hFF) << 24) | ((d & 32'hFF00) << 8) | ((d >> 8) & 32'hFF00) | (d >> 24);
  endfunction

  function automatic bit is_bank(logic [15:0] p);
    return (p == 16'h0092) || (p >= 16'h0800 && p <= 16'h0851);
  endfunction

  // Port-bus responder: latency from port low bits, one-cycle acknowledge
  always @(negedge clk) begin
    if (!rst_n) begin
      io_ack = 0; wait_cnt = 0;
    end else if (io_ack) begin
      io_ack = 0;
    end else if (io_req) begin
      if (wait_cnt >= int'(io_port[1:0])) begin
        io_ack = 1; io_rdata = resp_data(io_port); n_req++;
        rec_port = io_port; rec_size = io_size; rec_wdata = io_wdata; rec_we = io_we;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  task automatic acc(input logic we, input logic [1:0] sz, input logic [31:0] addr,
                     input logic [31:0] wd, output logic [31:0] rd);
    int base;
    base = n_req;
    @(negedge clk);
    h_valid = 1; h_we = we; h_size = sz; h_addr = addr; h_wdata = wd;
    do @(negedge clk); while (!h_ready);
    rd = h_rdata; delta = n_req - base;
    h_valid = 0;
  endtask

  task automatic sweep(input bit pages, input string tag);
    logic [31:0] off, rd;
    logic [15:0] p;
    logic [1:0]  sz;
    for (int i = 0; i < 48; i++) begin
      off = (i * 32'h0001_5A37 + 32'h13) & 32'h7F_FFFF;
      p   = want_port(off, pages);
      if (is_bank(p)) continue;
      sz  = 2'(i % 3);
      acc(1, sz, 32'h8000_0000 + off, 32'hA1B2_C3D4 ^ (i << 4), rd);
      chk(delta == 1 && rec_port == p, {tag, " write port"}, {16'h0, rec_port}, {16'h0, p});
      chk(rec_we == 1 && rec_size == sz, "R5 write size", {30'h0, rec_size}, {30'h0, sz});
      chk(rec_wdata == want_swap(sz, 32'hA1B2_C3D4 ^ (i << 4)), "R5 write lanes",
          rec_wdata, want_swap(sz, 32'hA1B2_C3D4 ^ (i << 4)));
      acc(0, sz, 32'h8000_0000 + off, 32'h0, rd);
      chk(delta == 1 && rec_port == p && rec_we == 0, {tag, " read port"}, {16'h0, rec_port}, {16'h0, p});
      chk(rd == want_swap(sz, resp_data(p)), "R6 read lanes", rd, want_swap(sz, resp_data(p)));
    end
  endtask

  task automatic bank_read(input logic [31:0] addr, input logic [7:0] exp, input string tag);
    logic [31:0] rd;
    acc(0, 2'd2, addr, 32'h0, rd);
    chk(rd == {24'h0, exp} && delta == 0, tag, rd, {24'h0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk(h_ready == 0 && io_req == 0, "R11 reset idle", {31'h0, io_req}, 32'h0);
    rst_n = 1;
    bank_read(32'h8000_0850, 8'h00, "R2 mode resets to flat");
    bank_read(32'h8000_081C, 8'h00, "R9 cache reg reset");
    sweep(0, "R2");
    // Switch mapping
    acc(1, 2'd0, 32'h8000_0850, 32'h0000_0001, rd);
    chk(delta == 0, "R4 mode write local", delta, 0);
    bank_read(32'h8004_2010, 8'h01, "R4 mode readback in page map");
    sweep(1, "R3");
    acc(1, 2'd1, 32'h8004_2010, 32'h0000_0000, rd);
    bank_read(32'h8000_0850, 8'h00, "R4 back to flat");
    // Fixed values and unclaimed ports
    bank_read(32'h8000_0092, 8'h00, "R8 port 0092");
    bank_read(32'h8000_0818, 8'h00, "R8 lock port");
    bank_read(32'h8000_0800, 8'hEF, "R8 cpu id port");
    bank_read(32'h8000_080C, 8'h3C, "R8 equip port");
    bank_read(32'h8000_0801, 8'hFF, "R8 unclaimed 0801");
    bank_read(32'h8000_0830, 8'hFF, "R8 unclaimed 0830");
    bank_read(32'h8000_0851, 8'hFF, "R8 unclaimed 0851");
    acc(0, 2'd1, 32'h8000_0800, 32'h0, rd);
    chk(rd == 32'h0000_00EF, "R7 half read not swapped", rd, 32'h0000_00EF);
    // Cache-control register
    acc(1, 2'd2, 32'h8000_081C, 32'h1234_56FF, rd);
    bank_read(32'h8000_081C, 8'hC3, "R9 keeps 7:6,1:0");
    acc(1, 2'd0, 32'h8000_081C, 32'h0000_003C, rd);
    bank_read(32'h8000_081C, 8'h00, "R9 drops 5:2");
    acc(1, 2'd0, 32'h8000_081C, 32'h0000_0081, rd);
    bank_read(32'h8000_081C, 8'h81, "R9 stores 81");
    // Flush port write has no effect
    acc(1, 2'd0, 32'h8000_0814, 32'h0000_00AA, rd);
    chk(delta == 0, "R10 flush write local", delta, 0);
    bank_read(32'h8000_081C, 8'h81, "R10 cache unchanged");
    bank_read(32'h8000_0850, 8'h00, "R10 mode unchanged");
    bank_read(32'h8000_0814, 8'hFF, "R10 flush reads FF");
    // Outside the window
    acc(0, 2'd2, 32'h7FFF_FFFC, 32'h0, rd);
    chk(rd == 32'hFFFF_FFFF && delta == 0, "R1 below window", rd, 32'hFFFF_FFFF);
    acc(0, 2'd0, 32'h8080_0000, 32'h0, rd);
    chk(rd == 32'hFFFF_FFFF && delta == 0, "R1 above window", rd, 32'hFFFF_FFFF);
    acc(1, 2'd2, 32'h0000_0850, 32'h5, rd);
    chk(delta == 0, "R1 write outside", delta, 0);
    bank_read(32'h8000_0850, 8'h00, "R1 outside write ignored");
    acc(0, 2'd0, 32'h807F_FFFF, 32'h0, rd);
    chk(delta == 1 && rec_port == 16'hFFFF, "R1 last window byte", {16'h0, rec_port}, 32'hFFFF);
    @(negedge clk);
    chk(h_ready == 0, "R11 ready single pulse", {31'h0, h_ready}, 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule